// File: doc/BRIEF.md
# Multi-Frame SPI CRC8 Accumulator

This block follows 16-bit SPI frames as they cross a serial link and folds each one into a single 8-bit CRC that spans a fixed group of consecutive frames. Every frame carries a command byte in its upper half and a data byte in its lower half. The command byte enters the CRC first and the data byte second. Bits are taken most significant first. The generator is x^8+x^5+x^3+x^2+x+1, held as 0x2F with the top term implied, and the register starts each group at 0xFF.

A frame-valid strobe hands over one frame. The block then folds that frame in at one bit per clock over 16 cycles and raises `busy_o` for that time. When the seventh frame of a group is done, the block pulses a group-complete output and shows the group result on `crc_o`. It also reseeds itself for the next group. A host can return a received CRC byte with a check strobe, and a sticky mismatch flag records any difference. A synchronous clear brings the block back to a group boundary. The same logic serves write traffic and read traffic. A direction flag is sampled on the first frame of each group and reported with the result.

Top module: `frame_crc8_acc`

## Requirements
- R1: The group result equals the CRC of the group's frames, computed as follows. Start from seed 0xFF. For each frame in order, take frame bits 15:8 and then bits 7:0. For each byte, XOR it into the register, then do eight steps of shift-left, XORing 0x2F whenever the bit shifted out is 1.
- R2: `grp_done_o` is high for exactly one cycle, in the cycle just after the seventh accepted frame of a group finishes. It stays low after frames one to six. The accumulator is reseeded to 0xFF, so each group's result does not depend on earlier groups.
- R3: `crc_o` reads 0xFF after reset or clear. It changes only when an accepted frame finishes, and then it shows the running CRC through that frame. After the seventh frame it shows the group result.
- R4: `busy_o` rises in the cycle after an accepted strobe and stays high for exactly 16 cycles. `crc_o` is updated in the first cycle in which `busy_o` is low again.
- R5: A frame-valid strobe that arrives while `busy_o` is high is ignored. It changes neither the CRC, nor the frame count, nor the bit timing.
- R6: `clr_i` reseeds the CRC to 0xFF, sets the frame count to zero, aborts any frame in progress and clears `mismatch_o`. All of this is seen one cycle later.
- R7: A check strobe that compares `chk_crc_i` with the most recent group result sets `mismatch_o` when the two differ. An equal byte leaves the flag as it was.
- R8: Once set, `mismatch_o` stays high through later frames and checks until a clear or a reset.
- R9: A check strobe before any group has completed since reset or clear is ignored. `mismatch_o` stays low.
- R10: `grp_dir_o` carries the `dir_i` value sampled on the first frame of the completed group. It is updated together with `grp_done_o`. The direction flag never changes the CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Group realign: reseed, zero frame count, clear mismatch |
| frm_vld_i | input | 1 | Frame-valid strobe |
| frm_data_i | input | 16 | Frame, command in 15:8, data in 7:0 |
| dir_i | input | 1 | Traffic direction (1 = read, 0 = write) |
| chk_vld_i | input | 1 | Received-CRC check strobe |
| chk_crc_i | input | 8 | Received CRC byte to compare |
| busy_o | output | 1 | Frame being folded in |
| crc_o | output | 8 | Running or group CRC |
| grp_done_o | output | 1 | One-cycle group-complete pulse |
| grp_dir_o | output | 1 | Direction of the completed group |
| mismatch_o | output | 1 | Sticky CRC mismatch flag |

## Verification
The assertions assume that a frame is normally offered only while `busy_o` is low. They also assume that check strobes come after a group has completed and before the next one completes, so that they refer to a well-defined group result. The stimulus waits for `busy_o` to drop before offering each frame. It raises extra strobes during busy only in the directed case that tests their rejection. Clear pulses are given in the middle of a frame and in the middle of a group, at points the bench chooses on purpose, so the realignment properties are exercised with known timing.

// File: rtl/crc8_acc_pkg.sv
`timescale 1ns/1ps
package crc8_acc_pkg;
  localparam int CRC_W = 8;
  typedef logic [CRC_W-1:0] crc_t;
  typedef enum logic {ENG_IDLE, ENG_SHIFT} eng_state_e;
endpackage

// File: rtl/crc8_acc_engine.sv
`timescale 1ns/1ps
module crc8_acc_engine
  import crc8_acc_pkg::*;
#(
  parameter int   FRAME_W = 16,
  parameter crc_t POLY    = 8'h2F,
  parameter crc_t SEED    = 8'hFF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               reseed_i,
  output logic               busy_o,
  output logic               last_o,
  output crc_t               nxt_o
);
  localparam int BC_W = $clog2(FRAME_W);

  eng_state_e         st_q;
  logic [FRAME_W-1:0] sh_q;
  logic [BC_W-1:0]    bc_q;
  crc_t               acc_q;
  logic               fb;

  // one bit step: the outgoing top bit meets the next frame bit
  always_comb begin
    fb    = acc_q[CRC_W-1] ^ sh_q[FRAME_W-1];
    nxt_o = {acc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign busy_o = (st_q == ENG_SHIFT);
  assign last_o = busy_o && (bc_q == BC_W'(FRAME_W - 1));

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      st_q  <= ENG_IDLE;
      sh_q  <= '0;
      bc_q  <= '0;
      acc_q <= SEED;
    end else begin
      case (st_q)
        ENG_IDLE: begin
          if (start_i) begin
            sh_q <= frame_i;
            bc_q <= '0;
            st_q <= ENG_SHIFT;
          end
        end
        ENG_SHIFT: begin
          sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
          bc_q  <= bc_q + 1'b1;
          acc_q <= (last_o && reseed_i) ? SEED : nxt_o;
          if (last_o) st_q <= ENG_IDLE;
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/crc8_acc_group.sv
`timescale 1ns/1ps
module crc8_acc_group
  import crc8_acc_pkg::*;
#(
  parameter int   GRP_FRAMES = 7,
  parameter crc_t SEED       = 8'hFF
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic accept_i,
  input  logic dir_i,
  input  logic last_i,
  input  crc_t crc_nxt_i,
  output logic grp_end_o,
  output crc_t crc_o,
  output logic grp_done_o,
  output logic grp_dir_o
);
  localparam int CNT_W = (GRP_FRAMES > 1) ? $clog2(GRP_FRAMES) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             dir_q;

  assign grp_end_o = last_i && (cnt_q == CNT_W'(GRP_FRAMES - 1));

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q      <= '0;
      dir_q      <= 1'b0;
      crc_o      <= SEED;
      grp_done_o <= 1'b0;
      grp_dir_o  <= 1'b0;
    end else begin
      grp_done_o <= grp_end_o;
      if (accept_i && cnt_q == '0) dir_q <= dir_i;
      if (last_i) begin
        crc_o <= crc_nxt_i;
        cnt_q <= grp_end_o ? '0 : cnt_q + 1'b1;
      end
      if (grp_end_o) grp_dir_o <= dir_q;
    end
  end
endmodule

// File: rtl/crc8_acc_compare.sv
`timescale 1ns/1ps
module crc8_acc_compare
  import crc8_acc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic grp_end_i,
  input  crc_t crc_nxt_i,
  input  logic chk_vld_i,
  input  crc_t chk_crc_i,
  output logic mismatch_o
);
  crc_t res_q;
  logic res_vld_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      res_q      <= '0;
      res_vld_q  <= 1'b0;
      mismatch_o <= 1'b0;
    end else begin
      if (grp_end_i) begin
        res_q     <= crc_nxt_i;
        res_vld_q <= 1'b1;
      end
      if (chk_vld_i && res_vld_q && (chk_crc_i != res_q)) mismatch_o <= 1'b1;
    end
  end
endmodule

// File: rtl/frame_crc8_acc.sv
`timescale 1ns/1ps
module frame_crc8_acc
  import crc8_acc_pkg::*;
#(
  parameter int   FRAME_W    = 16,
  parameter int   GRP_FRAMES = 7,
  parameter crc_t POLY       = 8'h2F,
  parameter crc_t SEED       = 8'hFF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic               frm_vld_i,
  input  logic [FRAME_W-1:0] frm_data_i,
  input  logic               dir_i,
  input  logic               chk_vld_i,
  input  logic [CRC_W-1:0]   chk_crc_i,
  output logic               busy_o,
  output logic [CRC_W-1:0]   crc_o,
  output logic               grp_done_o,
  output logic               grp_dir_o,
  output logic               mismatch_o
);
  logic accept, last, grp_end;
  crc_t crc_nxt;

  assign accept = frm_vld_i && !busy_o;

  crc8_acc_engine #(.FRAME_W(FRAME_W), .POLY(POLY), .SEED(SEED)) u_eng (
    .clk(clk), .rst(rst), .clr_i(clr_i), .start_i(accept), .frame_i(frm_data_i),
    .reseed_i(grp_end), .busy_o(busy_o), .last_o(last), .nxt_o(crc_nxt)
  );

  crc8_acc_group #(.GRP_FRAMES(GRP_FRAMES), .SEED(SEED)) u_grp (
    .clk(clk), .rst(rst), .clr_i(clr_i), .accept_i(accept), .dir_i(dir_i),
    .last_i(last), .crc_nxt_i(crc_nxt), .grp_end_o(grp_end), .crc_o(crc_o),
    .grp_done_o(grp_done_o), .grp_dir_o(grp_dir_o)
  );

  crc8_acc_compare u_cmp (
    .clk(clk), .rst(rst), .clr_i(clr_i), .grp_end_i(grp_end), .crc_nxt_i(crc_nxt),
    .chk_vld_i(chk_vld_i), .chk_crc_i(chk_crc_i), .mismatch_o(mismatch_o)
  );
endmodule

// File: rtl/crc8_acc_checker.sv
`timescale 1ns/1ps
module crc8_acc_checker
  import crc8_acc_pkg::*;
#(
  parameter int   FRAME_W = 16,
  parameter crc_t SEED    = 8'hFF
) (
  input logic       clk,
  input logic       rst,
  input logic       clr_i,
  input logic       chk_vld_i,
  input logic       busy_o,
  input logic [7:0] crc_o,
  input logic       grp_done_o,
  input logic       mismatch_o
);
  localparam int RUN_W = $clog2(FRAME_W + 1);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) run_q <= '0;
    else if (busy_o)  run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && $past(busy_o) && !$past(clr_i)) |-> run_q == RUN_W'(FRAME_W)); // R4
  AST_BUSY_MAX: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> run_q < RUN_W'(FRAME_W)); // R4
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !clr_i) |=> (!busy_o || run_q == $past(run_q) + 1'b1)); // R5
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    grp_done_o |-> (!busy_o && $past(busy_o))); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    grp_done_o |=> !grp_done_o); // R2
  AST_CRC_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !clr_i) |=> $stable(crc_o)); // R3
  AST_CRC_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !clr_i) |=> ($stable(crc_o) || !busy_o)); // R3
  AST_CLEAR_SEED: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (crc_o == SEED && !busy_o && !mismatch_o)); // R6
  AST_MISM_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(mismatch_o) |-> $past(chk_vld_i)); // R7
  AST_MISM_STICKY: assert property (@(posedge clk) disable iff (rst)
    (mismatch_o && !clr_i) |=> mismatch_o); // R8
endmodule

bind frame_crc8_acc crc8_acc_checker #(.FRAME_W(FRAME_W), .SEED(SEED)) u_chk (
  .clk(clk), .rst(rst), .clr_i(clr_i), .chk_vld_i(chk_vld_i), .busy_o(busy_o),
  .crc_o(crc_o), .grp_done_o(grp_done_o), .mismatch_o(mismatch_o)
);

// File: tb/tb_frame_crc8_acc.sv
`timescale 1ns/1ps
module tb_frame_crc8_acc;
  localparam int GN = 7;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1, clr_i = 1'b0, frm_vld_i = 1'b0, dir_i = 1'b0;
  logic [15:0] frm_data_i = '0;
  logic        chk_vld_i = 1'b0;
  logic [7:0]  chk_crc_i = '0;
  logic        busy_o, grp_done_o, grp_dir_o, mismatch_o;
  logic [7:0]  crc_o;

  frame_crc8_acc dut (
    .clk(clk), .rst(rst), .clr_i(clr_i), .frm_vld_i(frm_vld_i), .frm_data_i(frm_data_i),
    .dir_i(dir_i), .chk_vld_i(chk_vld_i), .chk_crc_i(chk_crc_i), .busy_o(busy_o),
    .crc_o(crc_o), .grp_done_o(grp_done_o), .grp_dir_o(grp_dir_o), .mismatch_o(mismatch_o)
  );

  int n_chk = 0, n_fail = 0;
  typedef struct packed { logic [7:0] crc; logic dir; } exp_t;
  exp_t q[$];
  logic [7:0] run_ref = 8'hFF;
  int         cnt_ref = 0;
  logic       gdir = 1'b0;
  logic [7:0] last_grp = 8'h00;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // byte-wise reference: XOR the byte in, then eight shift/poly steps
  function automatic logic [7:0] ref_frame(input logic [7:0] c, input logic [15:0] f);
    logic [7:0] b;
    for (int k = 0; k < 2; k++) begin
      b = (k == 0) ? f[15:8] : f[7:0];
      c = c ^ b;
      for (int j = 0; j < 8; j++) c = c[7] ? ((c << 1) ^ 8'h2F) : (c << 1);
    end
    return c;
  endfunction

  // monitor: pops the scoreboard on each group-complete pulse
  always @(negedge clk) begin
    if (!rst && grp_done_o) begin
      exp_t e;
      if (q.size() == 0) chk(1'b0, "R2 unexpected group done", 1, 0);
      else begin
        e = q.pop_front();
        chk(crc_o == e.crc, "R1 group crc", crc_o, e.crc);
        chk(grp_dir_o == e.dir, "R10 group dir", grp_dir_o, e.dir);
      end
    end
  end

  // driver: updates the model, pushes expected group result, drives frame
  task automatic send_frame(input logic [15:0] f, input logic d, input bit inject, output int blen);
    if (cnt_ref == 0) gdir = d;
    run_ref = ref_frame(run_ref, f);
    cnt_ref++;
    if (cnt_ref == GN) begin
      q.push_back('{crc: run_ref, dir: gdir});
      last_grp = run_ref;
    end
    @(negedge clk); frm_vld_i = 1'b1; frm_data_i = f; dir_i = d;
    @(negedge clk); frm_vld_i = 1'b0; blen = 0;
    while (busy_o) begin
      blen++;
      if (inject && blen == 5) begin frm_vld_i = 1'b1; frm_data_i = ~f; dir_i = ~d; end
      else frm_vld_i = 1'b0;
      @(negedge clk);
    end
    frm_vld_i = 1'b0;
    chk(crc_o == run_ref, "R3 running crc", crc_o, run_ref);
    chk(grp_done_o == (cnt_ref == GN), "R2 done only after seventh frame", grp_done_o, cnt_ref == GN);
    if (cnt_ref == GN) begin cnt_ref = 0; run_ref = 8'hFF; end
  endtask

  task automatic send_group(input logic [15:0] f[GN], input logic d0, input bit inject);
    int bl;
    for (int i = 0; i < GN; i++) send_frame(f[i], (i == 0) ? d0 : ~d0, inject && (i % 3 == 1), bl);
  endtask

  task automatic do_clear();
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
    run_ref = 8'hFF; cnt_ref = 0;
    chk(crc_o == 8'hFF && !busy_o && !mismatch_o, "R6 clear state", {busy_o, mismatch_o, crc_o}, 8'hFF);
  endtask

  task automatic send_chk(input logic [7:0] b);
    @(negedge clk); chk_vld_i = 1'b1; chk_crc_i = b;
    @(negedge clk); chk_vld_i = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R4 watchdog expired act=1 exp=0");
    report();
    $finish;
  end

  initial begin
    logic [15:0] g[GN];
    logic [7:0]  zcrc;
    int          bl;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(crc_o == 8'hFF, "R3 reset seed", crc_o, 8'hFF);
    chk(!busy_o && !grp_done_o && !mismatch_o, "R3 reset flags", {busy_o, grp_done_o, mismatch_o}, 0);

    // R9: check before any completed group
    send_chk(8'h00);
    chk(!mismatch_o, "R9 early check ignored", mismatch_o, 0);

    // all-zero group, first frame measures busy length (R4)
    send_frame(16'h0000, 1'b0, 1'b0, bl);
    chk(bl == 16, "R4 busy length", bl, 16);
    for (int i = 1; i < GN; i++) send_frame(16'h0000, 1'b0, 1'b0, bl);
    zcrc = crc_o;

    // one frame changed -> distinct result (R1)
    foreach (g[i]) g[i] = 16'h0000;
    g[3] = 16'h0100;
    send_group(g, 1'b0, 1'b0);
    chk(crc_o != zcrc, "R1 single-frame change alters crc", crc_o, zcrc);

    // R7: equal byte no flag, differing byte sets flag
    send_chk(last_grp);
    chk(!mismatch_o, "R7 equal byte no mismatch", mismatch_o, 0);
    send_chk(last_grp ^ 8'h01);
    chk(mismatch_o, "R7 differing byte mismatch", mismatch_o, 1);
    // R8: sticky through frames and good checks
    send_frame(16'h1234, 1'b0, 1'b0, bl);
    send_chk(last_grp);
    chk(mismatch_o, "R8 mismatch sticky", mismatch_o, 1);
    do_clear();
    chk(!mismatch_o, "R8 clear drops mismatch", mismatch_o, 0);

    // R9 again after clear
    send_chk(8'h5A);
    chk(!mismatch_o, "R9 check after clear ignored", mismatch_o, 0);

    // R5: strobes during busy ignored
    foreach (g[i]) g[i] = 16'(16'h1111 * (i + 1));
    send_group(g, 1'b1, 1'b1);

    // R6: clear in mid-frame
    @(negedge clk); frm_vld_i = 1'b1; frm_data_i = 16'hBEEF;
    @(negedge clk); frm_vld_i = 1'b0;
    repeat (4) @(negedge clk);
    do_clear();
    // R6: clear in mid-group, then full group from seed
    for (int i = 0; i < 3; i++) send_frame(16'hA5A5, 1'b0, 1'b0, bl);
    q.delete();
    do_clear();
    foreach (g[i]) g[i] = 16'(16'h0F0F ^ (i << 4));
    send_group(g, 1'b1, 1'b0);

    // R10: direction does not alter crc, same frames both directions
    zcrc = last_grp;
    send_group(g, 1'b0, 1'b0);
    chk(crc_o == zcrc, "R10 dir-independent crc", crc_o, zcrc);

    // random groups (R1, R2)
    for (int r = 0; r < 20; r++) begin
      foreach (g[i]) g[i] = 16'($urandom);
      send_group(g, 1'($urandom), 1'b0);
    end

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R2 all groups reported", q.size(), 0);
    report();
    $finish;
  end
endmodule